// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Override

This block controls the direction and drive strength of an eight-pin general-purpose I/O port. Software sets a per-pin direction and a per-pin reduced-drive select through two byte-wide registers on a simple register bus. Both registers can be read back at any time.

Each pin's effective output enable comes from a fixed priority chain of peripheral requests, and the chain differs from pin to pin. A timer output-compare enable wins on every pin. A routed PWM channel enable comes next, but only on the upper four pins. A periodic wakeup-timer output enable is a third level that exists on pin 5 alone. The software direction bit decides only when no override applies. An override never rewrites the stored direction bit, so software reads back what it last wrote. A two-bit source code per pin reports which agent currently controls that pin.

There is no state machine: the two registers are the only state. Everything else is combinational from the registers and the override inputs.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset both registers read 0x00, `pin_oe` is 0x00, `pin_rdrv` is 0x00, and with no override active every source code is 00.
- R2: The direction register sits at offset 0x0242. It is written on a clock edge where `bus_we` is high, and it reads back the last written value at any time. A direction bit of 1 means output and 0 means input.
- R3: The reduced-drive register sits at offset 0x0243 and is read and written the same way. Bit i drives `pin_rdrv[i]` directly (1 selects reduced drive), whatever the direction of pin i.
- R4: On any pin i, `tmr_oc_en[i]`=1 forces `pin_oe[i]`=1 and source code 01 (timer), whatever the other inputs are.
- R5: On pins 4 to 7, when the timer does not claim the pin, `pwm_ch_en[i]`=1 forces `pin_oe[i]`=1 and source code 10 (PWM). On pins 0 to 3, `pwm_ch_en` has no effect.
- R6: On pin 5 only, when neither the timer nor the PWM claims it, `wkp_out_en`=1 forces `pin_oe[5]`=1 and source code 11 (wakeup). Other pins ignore `wkp_out_en`.
- R7: When no override applies to pin i, `pin_oe[i]` equals direction bit i and the source code is 00 (software).
- R8: While an override forces a pin to output, its stored direction bit keeps the last value written and reads back unchanged.
- R9: A read at any other offset returns 0x00. A write to any other offset leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tmr_oc_en | input | 8 | Timer output-compare enable per channel |
| pwm_ch_en | input | 8 | Routed PWM channel enable per channel |
| wkp_out_en | input | 1 | Wakeup-timer output enable |
| pin_oe | output | 8 | Effective output enable per pin |
| pin_rdrv | output | 8 | Reduced-drive select per pin |
| pin_src | output | 16 | Controlling agent per pin, two bits per pin, pin i at [2i+1:2i]: 00 software, 01 timer, 10 PWM, 11 wakeup |

## Verification
The assertions assume that the override enables and the bus inputs are stable around each rising edge, and that `bus_we` is a single-cycle strobe qualified by the address. The bench drives all inputs on the falling edge, so every edge sees settled values. Random addresses are drawn so that the two mapped offsets and arbitrary unmapped offsets are all hit. Random override patterns include combinations where several overrides compete on the same pin.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_PWM = 2'd2,
        SRC_WKP = 2'd3
    } pin_src_e;

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
    parameter int          ADDR_W   = 16,
    parameter int          NPINS    = 8,
    parameter logic [15:0] DIR_OFFS = 16'h0242,
    parameter logic [15:0] DRV_OFFS = 16'h0243
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  drv_q
);

    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFFS);
    localparam logic [ADDR_W-1:0] DRV_A = ADDR_W'(DRV_OFFS);

    logic hit_dir;
    logic hit_drv;

    assign hit_dir = (bus_addr == DIR_A);
    assign hit_drv = (bus_addr == DRV_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            drv_q <= '0;
        end else if (bus_we) begin
            if (hit_dir) dir_q <= bus_wdata;
            if (hit_drv) drv_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_dir)      bus_rdata = dir_q;
        else if (hit_drv) bus_rdata = drv_q;
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && hit_dir) |=> $stable(dir_q));                           // R8
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && hit_drv) |=> $stable(drv_q));                           // R9
    AST_DRV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_drv) |=> (drv_q == $past(bus_wdata)));               // R3
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_dir) |=> (dir_q == $past(bus_wdata)));               // R2

endmodule

// File: rtl/gpio_ovr_pin_arb.sv
module gpio_ovr_pin_arb
    import gpio_ovr_pkg::*;
#(
    parameter bit HAS_PWM = 1'b0,
    parameter bit HAS_WKP = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dir_bit,
    input  logic     tmr_en,
    input  logic     pwm_en,
    input  logic     wkp_en,
    output logic     oe,
    output pin_src_e src
);

    logic pwm_live;
    logic wkp_live;

    assign pwm_live = HAS_PWM && pwm_en;
    assign wkp_live = HAS_WKP && wkp_en;

    always_comb begin
        if (tmr_en)        src = SRC_TMR;
        else if (pwm_live) src = SRC_PWM;
        else if (wkp_live) src = SRC_WKP;
        else               src = SRC_SW;
    end

    always_comb begin
        unique case (src)
            SRC_SW:  oe = dir_bit;
            SRC_TMR: oe = 1'b1;
            SRC_PWM: oe = 1'b1;
            SRC_WKP: oe = 1'b1;
            default: oe = dir_bit;
        endcase
    end

    AST_TMR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en |-> (oe && src == SRC_TMR));                                 // R4
    AST_SW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !pwm_en && !wkp_en) |-> (oe == dir_bit && src == SRC_SW)); // R7

    generate
        if (!HAS_PWM) begin : g_no_pwm
            AST_NO_PWM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                src != SRC_PWM);                                            // R5
        end
        if (!HAS_WKP) begin : g_no_wkp
            AST_NO_WKP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                src != SRC_WKP);                                            // R6
        end
    endgenerate

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          NPINS    = 8,
    parameter logic [15:0] DIR_OFFS = 16'h0242,
    parameter logic [15:0] DRV_OFFS = 16'h0243,
    parameter logic [7:0]  PWM_MASK = 8'hF0,
    parameter logic [7:0]  WKP_MASK = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [NPINS-1:0]    bus_wdata,
    output logic [NPINS-1:0]    bus_rdata,
    input  logic [NPINS-1:0]    tmr_oc_en,
    input  logic [NPINS-1:0]    pwm_ch_en,
    input  logic                wkp_out_en,
    output logic [NPINS-1:0]    pin_oe,
    output logic [NPINS-1:0]    pin_rdrv,
    output logic [2*NPINS-1:0]  pin_src
);

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] drv_q;

    gpio_ovr_regs #(
        .ADDR_W   (ADDR_W),
        .NPINS    (NPINS),
        .DIR_OFFS (DIR_OFFS),
        .DRV_OFFS (DRV_OFFS)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .drv_q     (drv_q)
    );

    assign pin_rdrv = drv_q;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            pin_src_e src_i;

            gpio_ovr_pin_arb #(
                .HAS_PWM (PWM_MASK[i % 8] && (i < 8)),
                .HAS_WKP (WKP_MASK[i % 8] && (i < 8))
            ) arb_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .dir_bit (dir_q[i]),
                .tmr_en  (tmr_oc_en[i]),
                .pwm_en  (pwm_ch_en[i]),
                .wkp_en  (wkp_out_en),
                .oe      (pin_oe[i]),
                .src     (src_i)
            );

            assign pin_src[2*i+1:2*i] = src_i;
        end
    endgenerate

    AST_RDRV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(DRV_OFFS)) |-> (bus_rdata == pin_rdrv));       // R3

endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;

    logic        clk;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [7:0]  tmr_oc_en;
    logic [7:0]  pwm_ch_en;
    logic        wkp_out_en;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_rdrv;
    logic [15:0] pin_src;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] m_dir;
    logic [7:0] m_drv;

    gpio_ovr_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tmr_oc_en  (tmr_oc_en),
        .pwm_ch_en  (pwm_ch_en),
        .wkp_out_en (wkp_out_en),
        .pin_oe     (pin_oe),
        .pin_rdrv   (pin_rdrv),
        .pin_src    (pin_src)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [1:0] exp_src(int i, logic [7:0] t, logic [7:0] p, logic w);
        if (t[i])                return 2'd1;
        else if (i >= 4 && p[i]) return 2'd2;
        else if (i == 5 && w)    return 2'd3;
        else                     return 2'd0;
    endfunction

    function automatic logic [7:0] exp_rd(logic [15:0] a);
        if (a == 16'h0242)      return m_dir;
        else if (a == 16'h0243) return m_drv;
        else                    return 8'h00;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [1:0] s;
        string      tag;
        for (int i = 0; i < 8; i++) begin
            s = exp_src(i, tmr_oc_en, pwm_ch_en, wkp_out_en);
            case (s)
                2'd1:    tag = "R4";
                2'd2:    tag = "R5";
                2'd3:    tag = "R6";
                default: tag = "R7";
            endcase
            check(tag, {14'd0, pin_src[2*i+:2]}, {14'd0, s});
            check(tag, {15'd0, pin_oe[i]}, {15'd0, (s != 2'd0) | m_dir[i]});
        end
        check("R3", {8'd0, pin_rdrv}, {8'd0, m_drv});
        if (bus_addr == 16'h0242)
            tag = (|tmr_oc_en || |pwm_ch_en || wkp_out_en) ? "R8" : "R2";
        else if (bus_addr == 16'h0243) tag = "R3";
        else tag = "R9";
        check(tag, {8'd0, bus_rdata}, {8'd0, exp_rd(bus_addr)});
    endtask

    task automatic step(logic [15:0] a, logic we, logic [7:0] wd,
                        logic [7:0] t, logic [7:0] p, logic w);
        @(negedge clk);
        bus_addr   = a;
        bus_we     = we;
        bus_wdata  = wd;
        tmr_oc_en  = t;
        pwm_ch_en  = p;
        wkp_out_en = w;
        #1;
        check_all();
        @(posedge clk);
        if (we && a == 16'h0242) m_dir = wd;
        if (we && a == 16'h0243) m_drv = wd;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ra;
        int          sel;
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_addr = 16'h0; bus_we = 1'b0; bus_wdata = 8'h0;
        tmr_oc_en = 8'h0; pwm_ch_en = 8'h0; wkp_out_en = 1'b0;
        m_dir = 8'h00; m_drv = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both registers and outputs
        step(16'h0242, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R1", {8'd0, bus_rdata}, 16'h0000);
        check("R1", {8'd0, pin_oe}, 16'h0000);
        check("R1", pin_src, 16'h0000);
        step(16'h0243, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R1", {8'd0, pin_rdrv}, 16'h0000);

        // R2 / R7: software direction
        step(16'h0242, 1'b1, 8'hA5, 8'h0, 8'h0, 1'b0);
        step(16'h0242, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        // R3: reduced drive independent of direction
        step(16'h0243, 1'b1, 8'h3C, 8'h0, 8'h0, 1'b0);
        step(16'h0243, 1'b0, 8'h0, 8'hFF, 8'hFF, 1'b1);
        // R4/R5/R6: competing overrides on pin 5, all direction bits zero
        step(16'h0242, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
        step(16'h0242, 1'b0, 8'h0, 8'h20, 8'h20, 1'b1);
        step(16'h0242, 1'b0, 8'h0, 8'h00, 8'h20, 1'b1);
        step(16'h0242, 1'b0, 8'h0, 8'h00, 8'h00, 1'b1);
        // R5/R6: PWM on low pins and wakeup on non-5 pins have no effect
        step(16'h0242, 1'b0, 8'h0, 8'h00, 8'h0F, 1'b1);
        // R8: write under override is stored, read back unchanged
        step(16'h0242, 1'b1, 8'h5A, 8'hFF, 8'hF0, 1'b1);
        step(16'h0242, 1'b0, 8'h0, 8'hFF, 8'hF0, 1'b1);
        step(16'h0242, 1'b0, 8'h0, 8'h00, 8'h00, 1'b0);
        // R9: unmapped write ignored, unmapped read zero
        step(16'h0244, 1'b1, 8'hFF, 8'h0, 8'h0, 1'b0);
        step(16'h0241, 1'b1, 8'hFF, 8'h0, 8'h0, 1'b0);
        step(16'h0242, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        step(16'h0243, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        step(16'h1242, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            sel = $urandom_range(0, 3);
            if (sel == 0)      ra = 16'h0242;
            else if (sel == 1) ra = 16'h0243;
            else begin
                ra = 16'($urandom);
                if (ra == 16'h0242 || ra == 16'h0243) ra = 16'h0000;
            end
            step(ra, 1'($urandom), 8'($urandom),
                 ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00,
                 8'($urandom), 1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule